// File: doc/BRIEF.md
# Widening Packed-Lane Subtractor

This block subtracts packed integer lanes and returns differences that are twice as wide as the source lanes. A 2-bit size code selects 8, 16 or 32-bit lanes. A signedness bit selects whether narrow lanes are zero-extended or sign-extended to double width before the subtraction. Each result lane keeps the low double-width bits of the difference, so it wraps and never saturates. Lane 0 sits in the least significant bits of every vector, and higher lanes follow toward the most significant bits.

A mode bit picks one of two operand shapes. In long mode, both operands are 64-bit vectors of narrow lanes. In wide mode, the first operand is a 128-bit vector that already holds double-width lanes, and the second operand is still a 64-bit vector of narrow lanes.

The block also checks the operation for illegal register choices. It flags the reserved size code, an odd destination register index, and, in wide mode only, an odd first-source index. When any of these is present, the result is forced to zero. The result, the illegal flag and the 128-bit destination slot (the destination index shifted right by one) are registered together. Every operation has the same one-cycle latency, whatever the data values.

Top module: `widen_lane_sub`

## Requirements
- R1: Lane width is 8 shifted left by `size_code` (0 gives 8 bits, 1 gives 16, 2 gives 32), and there are 64/width lanes. Result lane e occupies bits [e*2W +: 2W] of `result`, with lane 0 at the least significant end.
- R2: `size_code` 3 is reserved. It registers `illegal` = 1 and `result` = 0.
- R3: With `is_unsigned` = 1, narrow lanes are zero-extended before subtracting. With `is_unsigned` = 0, they are sign-extended.
- R4: In long mode (`wide_mode` = 0), the first operand lane e is `op_a[e*W +: W]` and `op_a[127:64]` is ignored. The second operand lane e is `op_b[e*W +: W]`.
- R5: In wide mode (`wide_mode` = 1), the first operand lane e is the double-width field `op_a[e*2W +: 2W]`, used without extension.
- R6: Each result lane is the difference modulo 2^(2W), with no saturation. For example, unsigned 32-bit 0 minus 0xFFFFFFFF gives 0xFFFFFFFF00000001.
- R7: An odd `dst_idx` (bit 0 set) registers `illegal` = 1 and `result` = 0.
- R8: In wide mode, `src1_idx_lsb` = 1 registers `illegal` = 1 and `result` = 0. In long mode, `src1_idx_lsb` has no effect.
- R9: `out_valid` equals `in_valid` from the previous clock edge, independent of the operand data.
- R10: After synchronous reset, `out_valid`, `illegal`, `result` and `dst_slot` are all zero.
- R11: While `in_valid` is 0, `result`, `illegal` and `dst_slot` hold their previous values.
- R12: `dst_slot` registers `dst_idx` shifted right by one for each accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| size_code | input | 2 | Lane size code (3 reserved) |
| is_unsigned | input | 1 | 1: zero-extend, 0: sign-extend |
| wide_mode | input | 1 | 1: first operand holds double-width lanes |
| dst_idx | input | 5 | Destination register index |
| src1_idx_lsb | input | 1 | Low bit of first-source register index |
| op_a | input | 128 | First operand (low 64 bits used in long mode) |
| op_b | input | 64 | Second operand, narrow lanes |
| out_valid | output | 1 | Registered result valid |
| illegal | output | 1 | Registered illegal-operation flag |
| result | output | 128 | Registered double-width differences |
| dst_slot | output | 4 | Registered 128-bit destination slot |

## Verification
The hardest cases to reach are the lane-boundary carries. One is a borrow that must stay inside its own double-width lane. Another is the worst-case extension, such as zero minus the largest unsigned value, or the most negative minus the most positive signed value. Uniform random data rarely produces every lane at these extremes at once. Directed vectors therefore fill every lane with the extreme patterns for each size, both signedness settings and both modes. These vectors are mixed with random legal and illegal encodings, including odd first-source indices in long mode, which must stay legal.

// File: rtl/wls_pkg.sv
package wls_pkg;
  localparam int SRC_W       = 64;
  localparam int DST_W       = 2 * SRC_W;
  localparam int IDX_W       = 5;
  localparam int BASE_LANE_W = 8;
  localparam int SIZE_W      = 2;
  localparam int NUM_SIZES   = 3;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lane_size_e;
endpackage

// File: rtl/wls_lane_sub.sv
module wls_lane_sub #(
  parameter int LW = 8
) (
  input  logic [2*LW-1:0] a_wide,
  input  logic [LW-1:0]   a_narrow,
  input  logic [LW-1:0]   b_narrow,
  input  logic            is_unsigned,
  input  logic            wide_mode,
  output logic [2*LW-1:0] diff
);
  logic [2*LW-1:0] ext_a;
  logic [2*LW-1:0] ext_b;
  logic            fill_a;
  logic            fill_b;

  always_comb begin
    fill_a = ~is_unsigned & a_narrow[LW-1];
    fill_b = ~is_unsigned & b_narrow[LW-1];
    ext_a  = wide_mode ? a_wide : {{LW{fill_a}}, a_narrow};
    ext_b  = {{LW{fill_b}}, b_narrow};
    diff   = ext_a - ext_b;
  end
endmodule

// File: rtl/wls_size_path.sv
module wls_size_path #(
  parameter int SRC_W  = 64,
  parameter int BASE_W = 8,
  parameter int SHIFT  = 0
) (
  input  logic [2*SRC_W-1:0] op_a,
  input  logic [SRC_W-1:0]   op_b,
  input  logic               is_unsigned,
  input  logic               wide_mode,
  output logic [2*SRC_W-1:0] res
);
  localparam int LW    = BASE_W << SHIFT;
  localparam int LANES = SRC_W / LW;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    wls_lane_sub #(.LW(LW)) u_lane (
      .a_wide      (op_a[e*2*LW +: 2*LW]),
      .a_narrow    (op_a[e*LW +: LW]),
      .b_narrow    (op_b[e*LW +: LW]),
      .is_unsigned (is_unsigned),
      .wide_mode   (wide_mode),
      .diff        (res[e*2*LW +: 2*LW])
    );
  end
endmodule

// File: rtl/wls_decode.sv
module wls_decode
  import wls_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code,
  input  logic              wide_mode,
  input  logic              dst_lsb,
  input  logic              src1_lsb,
  output logic              illegal
);
  logic rsvd_size;
  always_comb begin
    rsvd_size = (lane_size_e'(size_code) == SZ_RSVD);
    illegal   = rsvd_size | dst_lsb | (wide_mode & src1_lsb);
  end
endmodule

// File: rtl/wls_out_stage.sv
module wls_out_stage #(
  parameter int DW = 128,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          illegal_in,
  input  logic [DW-1:0] data_in,
  input  logic [SW-1:0] slot_in,
  output logic          out_valid,
  output logic          illegal,
  output logic [DW-1:0] result,
  output logic [SW-1:0] dst_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      dst_slot  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal  <= illegal_in;
        result   <= illegal_in ? '0 : data_in;
        dst_slot <= slot_in;
      end
    end
  end
endmodule

// File: rtl/widen_lane_sub.sv
module widen_lane_sub
  import wls_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SIZE_W-1:0]   size_code,
  input  logic                is_unsigned,
  input  logic                wide_mode,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic                src1_idx_lsb,
  input  logic [DST_W-1:0]    op_a,
  input  logic [SRC_W-1:0]    op_b,
  output logic                out_valid,
  output logic                illegal,
  output logic [DST_W-1:0]    result,
  output logic [IDX_W-2:0]    dst_slot
);
  logic [DST_W-1:0] path_res [NUM_SIZES];
  logic [DST_W-1:0] sel_res;
  logic             illegal_c;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    wls_size_path #(.SRC_W(SRC_W), .BASE_W(BASE_LANE_W), .SHIFT(s)) u_path (
      .op_a        (op_a),
      .op_b        (op_b),
      .is_unsigned (is_unsigned),
      .wide_mode   (wide_mode),
      .res         (path_res[s])
    );
  end

  always_comb begin
    unique case (lane_size_e'(size_code))
      SZ_BYTE: sel_res = path_res[0];
      SZ_HALF: sel_res = path_res[1];
      SZ_WORD: sel_res = path_res[2];
      default: sel_res = '0;
    endcase
  end

  wls_decode u_decode (
    .size_code (size_code),
    .wide_mode (wide_mode),
    .dst_lsb   (dst_idx[0]),
    .src1_lsb  (src1_idx_lsb),
    .illegal   (illegal_c)
  );

  wls_out_stage #(.DW(DST_W), .SW(IDX_W-1)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .illegal_in (illegal_c),
    .data_in    (sel_res),
    .slot_in    (dst_idx[IDX_W-1:1]),
    .out_valid  (out_valid),
    .illegal    (illegal),
    .result     (result),
    .dst_slot   (dst_slot)
  );
endmodule

// File: rtl/wls_checker.sv
module wls_checker
  import wls_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SIZE_W-1:0] size_code,
  input logic              wide_mode,
  input logic [IDX_W-1:0]  dst_idx,
  input logic              src1_idx_lsb,
  input logic              out_valid,
  input logic              illegal,
  input logic [DST_W-1:0]  result,
  input logic [IDX_W-2:0]  dst_slot
);
  assert_valid_on_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_off_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_rsvd_size_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd3) |=> (illegal && result == '0));
  assert_odd_dst_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_idx[0]) |=> illegal);
  assert_wide_src_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_mode && src1_idx_lsb) |=> illegal);
  assert_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code != 2'd3 && !dst_idx[0] && !(wide_mode && src1_idx_lsb))
      |=> !illegal);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal) && $stable(dst_slot)));
  assert_slot_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (dst_slot == $past(dst_idx[IDX_W-1:1])));
endmodule

bind widen_lane_sub wls_checker u_wls_checker (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .size_code    (size_code),
  .wide_mode    (wide_mode),
  .dst_idx      (dst_idx),
  .src1_idx_lsb (src1_idx_lsb),
  .out_valid    (out_valid),
  .illegal      (illegal),
  .result       (result),
  .dst_slot     (dst_slot)
);

// File: tb/test_widen_lane_sub.sv
module test_widen_lane_sub;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   size_code = '0;
  logic         is_unsigned = 1'b0;
  logic         wide_mode = 1'b0;
  logic [4:0]   dst_idx = '0;
  logic         src1_idx_lsb = 1'b0;
  logic [127:0] op_a = '0;
  logic [63:0]  op_b = '0;
  logic         out_valid;
  logic         illegal;
  logic [127:0] result;
  logic [3:0]   dst_slot;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  widen_lane_sub i_widen_lane_sub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .is_unsigned(is_unsigned), .wide_mode(wide_mode), .dst_idx(dst_idx),
    .src1_idx_lsb(src1_idx_lsb), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .illegal(illegal), .result(result), .dst_slot(dst_slot)
  );

  function automatic logic [127:0] ref_sub(logic [1:0] sz, logic uns, logic wide,
                                           logic [127:0] a, logic [63:0] b);
    logic [127:0] r;
    int lw;
    logic [63:0] m1, m2;
    r  = '0;
    lw = 8 << sz;
    m1 = (64'd1 << lw) - 64'd1;
    m2 = (lw == 32) ? '1 : ((64'd1 << (2 * lw)) - 64'd1);
    for (int e = 0; e < 64 / lw; e++) begin
      logic [127:0] ta, tb;
      logic [63:0] av, bv, dv;
      ta = wide ? (a >> (e * 2 * lw)) : (a >> (e * lw));
      tb = {64'd0, b} >> (e * lw);
      av = wide ? (ta[63:0] & m2) : (ta[63:0] & m1);
      bv = tb[63:0] & m1;
      if (!wide && !uns && av[lw-1]) av = av | ~m1;
      if (!uns && bv[lw-1]) bv = bv | ~m1;
      dv = (av - bv) & m2;
      r  = r | ({64'd0, dv} << (e * 2 * lw));
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] sz, logic uns, logic wide, logic [4:0] di,
                       logic s1, logic [127:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; size_code = sz; is_unsigned = uns; wide_mode = wide;
    dst_idx = di; src1_idx_lsb = s1; op_a = a; op_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run_and_check(string req, logic [1:0] sz, logic uns, logic wide,
                               logic [4:0] di, logic s1, logic [127:0] a, logic [63:0] b);
    logic bad;
    bad = (sz == 2'd3) || di[0] || (wide && s1);
    apply(sz, uns, wide, di, s1, a, b);
    check({req, " valid R9"}, {127'd0, out_valid}, 128'd1);
    check({req, " flag"}, {127'd0, illegal}, {127'd0, bad});
    check({req, " data"}, result, bad ? 128'd0 : ref_sub(sz, uns, wide, a, b));
    check({req, " slot R12"}, {124'd0, dst_slot}, {124'd0, di[4:1]});
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    logic [127:0] prev;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 out_valid", {127'd0, out_valid}, 128'd0);
    check("R10 illegal", {127'd0, illegal}, 128'd0);
    check("R10 result", result, 128'd0);
    check("R10 slot", {124'd0, dst_slot}, 128'd0);
    @(negedge clk);
    rst = 1'b0;

    // R6 hardcoded extremes
    apply(2'd2, 1'b1, 1'b0, 5'd4, 1'b0, 128'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 u32 0-max", result, {2{64'hFFFF_FFFF_0000_0001}});
    apply(2'd0, 1'b0, 1'b0, 5'd2, 1'b0, {64'd0, {8{8'h80}}}, {8{8'h7F}});
    check("R3 s8 min-max", result, {8{16'hFF01}});
    apply(2'd0, 1'b1, 1'b0, 5'd2, 1'b0, {64'd0, {8{8'h80}}}, {8{8'h7F}});
    check("R3 u8 0x80-0x7F", result, {8{16'h0001}});
    apply(2'd1, 1'b0, 1'b1, 5'd6, 1'b1, 128'd0, 64'd0);
    check("R8 wide odd src", {127'd0, illegal}, 128'd1);
    check("R8 wide odd src zero", result, 128'd0);

    // R1 R3 R4 R5 extremes per size, sign and mode
    for (int sz = 0; sz < 3; sz++) begin
      for (int u = 0; u < 2; u++) begin
        for (int w = 0; w < 2; w++) begin
          run_and_check("R1 R3 R4 R5 zero-max", sz[1:0], u[0], w[0], 5'd8, 1'b0,
                        128'd0, '1);
          run_and_check("R3 R6 min-max", sz[1:0], u[0], w[0], 5'd10, 1'b0,
                        {16{8'h80}} & ~({16{8'h7F}}), {8{8'h7F}});
          run_and_check("R4 upper ignored", sz[1:0], u[0], w[0], 5'd12, 1'b0,
                        {64'hDEAD_BEEF_1234_5678, 64'h0102_0304_0506_0708},
                        64'h1122_3344_5566_7788);
        end
      end
    end

    // R2 R7 R8 directed illegal and long-mode odd source
    run_and_check("R2 reserved size", 2'd3, 1'b0, 1'b0, 5'd0, 1'b0, '1, 64'd5);
    run_and_check("R7 odd dst", 2'd1, 1'b1, 1'b0, 5'd7, 1'b0, '1, 64'd5);
    run_and_check("R8 long odd src legal", 2'd1, 1'b1, 1'b0, 5'd30, 1'b1,
                  128'h1234, 64'h9876);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      run_and_check("R1 R6 random", sz, 1'($urandom), 1'($urandom),
                    5'($urandom), 1'($urandom),
                    {$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom});
    end

    // R11 hold while idle
    run_and_check("R11 setup", 2'd0, 1'b0, 1'b0, 5'd20, 1'b0, 128'h55, 64'h77);
    prev = result;
    @(negedge clk);
    in_valid = 1'b0; dst_idx = 5'd3; op_a = '1; size_code = 2'd3;
    @(posedge clk);
    #1;
    check("R9 idle valid", {127'd0, out_valid}, 128'd0);
    check("R11 result hold", result, prev);
    check("R11 flag hold", {127'd0, illegal}, 128'd0);
    check("R11 slot hold", {124'd0, dst_slot}, 128'd10);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule